// File: doc/BRIEF.md
# Two-Wire Bus Master Register Bank

This block is the software-facing register file of a two-wire serial bus master. A processor reaches it through a simple 32-bit word-addressed write port and a combinational read port. It holds the clock and bus configuration, the slave address, 64 bits of transfer data and a command word. It passes all of these as plain register images to a separate transfer engine, which carries out the bus protocol.

The command register is the launch trigger. Software stores a command while the bank is idle, and the bank gives the engine a one-cycle start pulse. Until the engine reports completion, a busy register reads 1 and further command writes are dropped. On completion the bank sets a done flag together with up to four failure causes: lost arbitration, no response, data collision and bus busy. It captures the engine's receive data into the two data registers. A level interrupt is raised through a per-bit mask. Software clears status bits by writing ones to them.

The sequencing is a three-state machine:

- ST_IDLE waits for a command write. The LAUNCH transition moves it to ST_LAUNCH.
- ST_LAUNCH drives the start pulse for one cycle, then moves unconditionally to ST_WAIT.
- ST_WAIT holds busy until the engine's done pulse. The COMPLETE transition then returns it to ST_IDLE.

Top module: `twi_regbank`

## Requirements
- R1: After reset, both clock registers (word offsets 0x00 and 0x04) read 0x301F and the configuration register (0x08) reads 0x3302. Command, address, data, status, mask and busy registers read 0, and irq is low.
- R2: Clock registers keep only bits 15:12 and 9:0 (write mask 0xF3FF). The configuration register keeps bits 15:4 and 1:0 (mask 0xFFF3). All other bits read 0.
- R3: A write to the command register (0x0C) while busy reads 0 stores wdata & 0x377 into the command register and onto eng_cmd. It raises eng_start for exactly the one cycle after the write. The busy register (0x24) then reads 1 until completion.
- R4: A command write while busy reads 1 is ignored: there is no start pulse and eng_cmd is unchanged.
- R5: An eng_done pulse while waiting for the engine sets status bit 0 (done). It ORs eng_err[0..3] into status bits 1..4 (lost arbitration, no response, data collision, bus busy). It loads eng_rdata[31:0] into data 0 (0x14) and eng_rdata[63:32] into data 1 (0x18). Busy reads 0 from the next cycle.
- R6: An eng_done pulse while no transaction is pending changes neither status nor the data registers.
- R7: Writing the status register (0x1C) clears exactly the bits set in wdata[4:0]. A completion in the same cycle still sets its bits.
- R8: irq is high exactly while (status AND mask) is nonzero. The mask register (0x20) keeps bits 4:0.
- R9: Offsets 0x28 to 0x3C read 0 and ignore writes. The busy register ignores writes.
- R10: The address register (0x10) keeps bits 9:0. Data 0 and data 1 are fully writable by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address; bits 5:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle transaction start |
| eng_cmd | output | 10 | Stored command word |
| eng_saddr | output | 10 | Slave address |
| eng_wdata | output | 64 | Data 1 then data 0 |
| eng_sf_clk | output | 16 | Standard/fast clock register image |
| eng_hs_clk | output | 16 | High-speed clock register image |
| eng_cfg | output | 16 | Configuration register image |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 4 | Failure causes, valid with eng_done |
| eng_rdata | input | 64 | Receive data, valid with eng_done |

## Verification
Two cases are the hardest to reach from the ports. The first is a status clear landing in the very cycle a completion sets bits. The second is a command write landing while the machine sits in ST_WAIT. The bench reaches both by driving the engine side by hand, holding eng_done back while it issues the colliding register writes in the chosen cycle. A stray done pulse from an idle engine is also injected, and the data registers are read afterwards to show they kept their earlier contents.

// File: rtl/twi_rb_pkg.sv
package twi_rb_pkg;
    localparam logic [3:0] OFF_SFCLK = 4'd0;
    localparam logic [3:0] OFF_HSCLK = 4'd1;
    localparam logic [3:0] OFF_CFG   = 4'd2;
    localparam logic [3:0] OFF_CMD   = 4'd3;
    localparam logic [3:0] OFF_SADDR = 4'd4;
    localparam logic [3:0] OFF_DAT0  = 4'd5;
    localparam logic [3:0] OFF_DAT1  = 4'd6;
    localparam logic [3:0] OFF_STS   = 4'd7;
    localparam logic [3:0] OFF_MSK   = 4'd8;
    localparam logic [3:0] OFF_BUSY  = 4'd9;

    localparam logic [15:0] CLK_KEEP  = 16'hF3FF;
    localparam logic [15:0] CLK_RESET = 16'h301F;
    localparam logic [15:0] CFG_KEEP  = 16'hFFF3;
    localparam logic [15:0] CFG_RESET = 16'h3302;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/twi_rb_ctrl.sv
module twi_rb_ctrl
    import twi_rb_pkg::*;
#(
    parameter int CMD_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_val,
    input  logic             eng_done,
    output logic             eng_start,
    output logic             busy,
    output logic             complete,
    output logic [CMD_W-1:0] cmd_q
);
    ctl_state_e state_q, state_d;
    logic       accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (eng_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_start = (state_q == ST_LAUNCH);
        busy      = (state_q != ST_IDLE);
        complete  = (state_q == ST_WAIT) && eng_done;
        accept    = (state_q == ST_IDLE) && cmd_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= cmd_val;
    end
endmodule

// File: rtl/twi_rb_status.sv
module twi_rb_status #(
    parameter int N_ERR = 4,
    localparam int STS_W = N_ERR + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_wr,
    input  logic             msk_wr,
    input  logic [STS_W-1:0] wbits,
    input  logic             complete,
    input  logic [N_ERR-1:0] eng_err,
    output logic [STS_W-1:0] sts_q,
    output logic [STS_W-1:0] msk_q,
    output logic             irq
);
    logic [STS_W-1:0] clr_bits;
    logic [STS_W-1:0] set_bits;
    logic [STS_W-1:0] sts_d;

    always_comb begin
        clr_bits = sts_wr   ? wbits : '0;
        set_bits = complete ? {eng_err, 1'b1} : '0;
        sts_d    = (sts_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (msk_wr) msk_q <= wbits;
        end
    end

    assign irq = |(sts_q & msk_q);
endmodule

// File: rtl/twi_rb_cfg.sv
module twi_rb_cfg
    import twi_rb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SADDR_W = 10,
    parameter int N_CLK   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          word_sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                complete,
    input  logic [2*DATA_W-1:0] eng_rdata,
    output logic [15:0]         clk_img [N_CLK],
    output logic [15:0]         cfg_img,
    output logic [SADDR_W-1:0]  saddr_q,
    output logic [DATA_W-1:0]   dat0_q,
    output logic [DATA_W-1:0]   dat1_q
);
    for (genvar i = 0; i < N_CLK; i++) begin : g_clkreg
        localparam logic [3:0] MY_OFF = OFF_SFCLK + 4'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                clk_img[i] <= CLK_RESET;
            else if (wr_en && word_sel == MY_OFF)
                clk_img[i] <= wdata[15:0] & CLK_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_img <= CFG_RESET;
            saddr_q <= '0;
        end else if (wr_en) begin
            if (word_sel == OFF_CFG)   cfg_img <= wdata[15:0] & CFG_KEEP;
            if (word_sel == OFF_SADDR) saddr_q <= wdata[SADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat0_q <= '0;
            dat1_q <= '0;
        end else if (complete) begin
            dat0_q <= eng_rdata[DATA_W-1:0];
            dat1_q <= eng_rdata[2*DATA_W-1:DATA_W];
        end else if (wr_en) begin
            if (word_sel == OFF_DAT0) dat0_q <= wdata;
            if (word_sel == OFF_DAT1) dat1_q <= wdata;
        end
    end
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_rb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SADDR_W = 10,
    parameter int CMD_W   = 10,
    parameter int N_ERR   = 4,
    localparam int STS_W  = N_ERR + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [5:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq,
    output logic                eng_start,
    output logic [CMD_W-1:0]    eng_cmd,
    output logic [SADDR_W-1:0]  eng_saddr,
    output logic [2*DATA_W-1:0] eng_wdata,
    output logic [15:0]         eng_sf_clk,
    output logic [15:0]         eng_hs_clk,
    output logic [15:0]         eng_cfg,
    input  logic                eng_done,
    input  logic [N_ERR-1:0]    eng_err,
    input  logic [2*DATA_W-1:0] eng_rdata
);
    localparam logic [CMD_W-1:0] CMD_KEEP = CMD_W'(10'h377);

    logic [3:0]        word_sel;
    logic              busy_w;
    logic              complete_w;
    logic              sts_wr;
    logic              msk_wr;
    logic              cmd_wr;
    logic [STS_W-1:0]  sts_q;
    logic [STS_W-1:0]  msk_q;
    logic [15:0]       clk_img [2];
    logic [15:0]       cfg_img;
    logic [DATA_W-1:0] dat0_q;
    logic [DATA_W-1:0] dat1_q;
    logic              unused_addr_bits;

    assign word_sel         = reg_addr[5:2];
    assign unused_addr_bits = ^reg_addr[1:0];
    assign cmd_wr           = reg_wr && (word_sel == OFF_CMD);
    assign sts_wr           = reg_wr && (word_sel == OFF_STS);
    assign msk_wr           = reg_wr && (word_sel == OFF_MSK);

    twi_rb_ctrl #(.CMD_W(CMD_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_val  (reg_wdata[CMD_W-1:0] & CMD_KEEP),
        .eng_done (eng_done),
        .eng_start(eng_start),
        .busy     (busy_w),
        .complete (complete_w),
        .cmd_q    (eng_cmd)
    );

    twi_rb_status #(.N_ERR(N_ERR)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .sts_wr  (sts_wr),
        .msk_wr  (msk_wr),
        .wbits   (reg_wdata[STS_W-1:0]),
        .complete(complete_w),
        .eng_err (eng_err),
        .sts_q   (sts_q),
        .msk_q   (msk_q),
        .irq     (irq)
    );

    twi_rb_cfg #(.DATA_W(DATA_W), .SADDR_W(SADDR_W), .N_CLK(2)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .word_sel (word_sel),
        .wdata    (reg_wdata),
        .complete (complete_w),
        .eng_rdata(eng_rdata),
        .clk_img  (clk_img),
        .cfg_img  (cfg_img),
        .saddr_q  (eng_saddr),
        .dat0_q   (dat0_q),
        .dat1_q   (dat1_q)
    );

    assign eng_sf_clk = clk_img[0];
    assign eng_hs_clk = clk_img[1];
    assign eng_cfg    = cfg_img;
    assign eng_wdata  = {dat1_q, dat0_q};

    always_comb begin
        reg_rdata = '0;
        unique case (word_sel)
            OFF_SFCLK: reg_rdata = DATA_W'(clk_img[0]);
            OFF_HSCLK: reg_rdata = DATA_W'(clk_img[1]);
            OFF_CFG:   reg_rdata = DATA_W'(cfg_img);
            OFF_CMD:   reg_rdata = DATA_W'(eng_cmd);
            OFF_SADDR: reg_rdata = DATA_W'(eng_saddr);
            OFF_DAT0:  reg_rdata = dat0_q;
            OFF_DAT1:  reg_rdata = dat1_q;
            OFF_STS:   reg_rdata = DATA_W'(sts_q);
            OFF_MSK:   reg_rdata = DATA_W'(msk_q);
            OFF_BUSY:  reg_rdata = DATA_W'(busy_w);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/twi_rb_chk.sv
module twi_rb_chk #(
    parameter int CMD_W = 10,
    parameter int STS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [5:0]       reg_addr,
    input logic             eng_start,
    input logic [CMD_W-1:0] eng_cmd,
    input logic             eng_done,
    input logic             busy,
    input logic             complete,
    input logic [STS_W-1:0] sts_q,
    input logic [STS_W-1:0] msk_q,
    input logic             irq
);
    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_start) |-> $past(reg_wr && reg_addr[5:2] == 4'd3 && !busy));

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr[5:2] == 4'd3) |=> (!eng_start && $stable(eng_cmd)));

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (sts_q[0] && !busy));

    // R6
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && eng_done && !(reg_wr && reg_addr[5:2] == 4'd7)) |=> $stable(sts_q));

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == '0) |-> !irq);
endmodule

bind twi_regbank twi_rb_chk #(.CMD_W(CMD_W), .STS_W(STS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .eng_start(eng_start),
    .eng_cmd  (eng_cmd),
    .eng_done (eng_done),
    .busy     (busy_w),
    .complete (complete_w),
    .sts_q    (sts_q),
    .msk_q    (msk_q),
    .irq      (irq)
);

// File: tb/sim_twi_regbank.sv
`timescale 1ns/1ps
module sim_twi_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, eng_start;
    logic [9:0]  eng_cmd, eng_saddr;
    logic [63:0] eng_wdata;
    logic [15:0] eng_sf_clk, eng_hs_clk, eng_cfg;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_err = '0;
    logic [63:0] eng_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    twi_regbank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_start(eng_start), .eng_cmd(eng_cmd), .eng_saddr(eng_saddr),
        .eng_wdata(eng_wdata), .eng_sf_clk(eng_sf_clk), .eng_hs_clk(eng_hs_clk),
        .eng_cfg(eng_cfg), .eng_done(eng_done), .eng_err(eng_err),
        .eng_rdata(eng_rdata)
    );

    // behavioural reference model
    logic [31:0] m_sf, m_hs, m_cfg, m_cmd, m_sa, m_d0, m_d1, m_sts, m_msk;
    int          m_phase;   // 0 idle, 1 launching, 2 waiting

    always @(posedge clk) begin
        bit fin;
        int w;
        if (!rst_n) begin
            m_sf = 32'h301F; m_hs = 32'h301F; m_cfg = 32'h3302;
            m_cmd = 0; m_sa = 0; m_d0 = 0; m_d1 = 0; m_sts = 0; m_msk = 0;
            m_phase = 0;
        end else begin
            w   = int'(reg_addr[5:2]);
            fin = (m_phase == 2) && eng_done;
            if (m_phase == 0 && reg_wr && w == 3) begin
                m_cmd = reg_wdata & 32'h377;
                m_phase = 1;
            end else if (m_phase == 1) m_phase = 2;
            else if (fin) m_phase = 0;
            if (reg_wr) begin
                if (w == 0) m_sf = reg_wdata & 32'hF3FF;
                if (w == 1) m_hs = reg_wdata & 32'hF3FF;
                if (w == 2) m_cfg = reg_wdata & 32'hFFF3;
                if (w == 4) m_sa = reg_wdata & 32'h3FF;
                if (w == 5) m_d0 = reg_wdata;
                if (w == 6) m_d1 = reg_wdata;
                if (w == 7) m_sts = m_sts & ~(reg_wdata & 32'h1F);
                if (w == 8) m_msk = reg_wdata & 32'h1F;
            end
            if (fin) begin
                m_sts = m_sts | {27'd0, eng_err, 1'b1};
                m_d0 = eng_rdata[31:0];
                m_d1 = eng_rdata[63:32];
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a[5:2])
            4'd0: return m_sf;
            4'd1: return m_hs;
            4'd2: return m_cfg;
            4'd3: return m_cmd;
            4'd4: return m_sa;
            4'd5: return m_d0;
            4'd6: return m_d1;
            4'd7: return m_sts;
            4'd8: return m_msk;
            4'd9: return (m_phase != 0) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 model rdata", 64'(reg_rdata), 64'(model_read(reg_addr)));
            chk("R8 model irq", 64'(irq), 64'((m_sts & m_msk) != 0));
            chk("R3 model start", 64'(eng_start), 64'(m_phase == 1));
            chk("R4 model cmd", 64'(eng_cmd), 64'(m_cmd[9:0]));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic done_pulse(input logic [3:0] e, input logic [63:0] d);
        @(posedge clk); #2;
        eng_done = 1'b1; eng_err = e; eng_rdata = d;
        @(posedge clk); #2;
        eng_done = 1'b0; eng_err = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset values
        rd(6'h00, 32'h301F, "R1 sf clk");
        rd(6'h04, 32'h301F, "R1 hs clk");
        rd(6'h08, 32'h3302, "R1 cfg");
        rd(6'h0C, 32'h0, "R1 cmd");
        rd(6'h1C, 32'h0, "R1 status");
        rd(6'h20, 32'h0, "R1 mask");
        rd(6'h24, 32'h0, "R1 busy");
        chk("R1 irq", 64'(irq), 64'd0);

        // R2 field masking
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, 32'hF3FF, "R2 sf clk mask");
        wr(6'h04, 32'h0000_1234); rd(6'h04, 32'h1234, "R2 hs clk");
        wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, 32'hFFF3, "R2 cfg mask");

        // R10 address and data
        wr(6'h10, 32'h0000_FFFF); rd(6'h10, 32'h3FF, "R10 saddr");
        wr(6'h14, 32'hDEAD_BEEF); rd(6'h14, 32'hDEAD_BEEF, "R10 data0");
        wr(6'h18, 32'h0123_4567); rd(6'h18, 32'h0123_4567, "R10 data1");
        chk("R10 eng_wdata", eng_wdata, 64'h0123_4567_DEAD_BEEF);

        // R9 unmapped and read-only
        wr(6'h28, 32'hFFFF_FFFF); rd(6'h28, 32'h0, "R9 unmapped");
        wr(6'h24, 32'h1); rd(6'h24, 32'h0, "R9 busy read-only");
        rd(6'h3C, 32'h0, "R9 top offset");

        // R8 mask register width
        wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, 32'h1F, "R8 mask bits");
        wr(6'h20, 32'h1);

        // R3 launch
        wr(6'h0C, 32'h0000_01FF);
        @(negedge clk);
        chk("R3 start pulse", 64'(eng_start), 64'd1);
        chk("R3 cmd masked", 64'(eng_cmd), 64'h177);
        rd(6'h24, 32'h1, "R3 busy");
        chk("R3 start ends", 64'(eng_start), 64'd0);

        // R4 write while busy
        wr(6'h0C, 32'h0);
        @(negedge clk);
        chk("R4 no restart", 64'(eng_start), 64'd0);
        chk("R4 cmd held", 64'(eng_cmd), 64'h177);

        // R5 completion with errors 0101
        done_pulse(4'b0101, 64'h1122_3344_5566_7788);
        rd(6'h1C, 32'h0B, "R5 status");
        rd(6'h24, 32'h0, "R5 busy cleared");
        rd(6'h14, 32'h5566_7788, "R5 data0 load");
        rd(6'h18, 32'h1122_3344, "R5 data1 load");
        chk("R8 irq done masked", 64'(irq), 64'd1);

        // R7 write-one-to-clear, R8 masking
        wr(6'h1C, 32'h1); rd(6'h1C, 32'h0A, "R7 clear done only");
        chk("R8 irq errors unmasked", 64'(irq), 64'd0);
        wr(6'h20, 32'h1F);
        @(negedge clk);
        chk("R8 irq all masked", 64'(irq), 64'd1);
        wr(6'h1C, 32'h1F); rd(6'h1C, 32'h0, "R7 clear all");
        chk("R8 irq after clear", 64'(irq), 64'd0);

        // R6 stray completion while idle
        done_pulse(4'hF, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(6'h1C, 32'h0, "R6 status untouched");
        rd(6'h14, 32'h5566_7788, "R6 data0 untouched");
        rd(6'h24, 32'h0, "R6 still idle");

        // R7 clear colliding with completion
        wr(6'h0C, 32'h0000_0001);
        repeat (3) @(posedge clk);
        #2;
        reg_wr = 1'b1; reg_addr = 6'h1C; reg_wdata = 32'h1F;
        eng_done = 1'b1; eng_err = 4'b1000; eng_rdata = 64'hA;
        @(posedge clk); #2;
        reg_wr = 1'b0; eng_done = 1'b0; eng_err = '0;
        rd(6'h1C, 32'h11, "R7 set wins over clear");
        rd(6'h14, 32'hA, "R5 data0 second load");

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule